// File: doc/BRIEF.md
# Polynomial-Noise Sampled Tone Channel

This block is one voice of a retro square-wave and noise sound generator. A down-counter loaded from a frequency value N emits one sample strobe every N+1 clocks. Three maximal-length shift-register noise sources run on every system clock. They never stop and are never realigned. The strobe only takes a snapshot of them. A 3-bit distortion select decides whether that snapshot gates a divide-by-two toggle stage or drives the output directly.

Because the noise sources keep running, the channel output is a subsample of a fast pseudo-random sequence, so its bits alias. The timbre a given N produces depends on where the noise sources stood when the divider last reloaded. Moving N away and back can change the sound. An N whose period matches a noise period can freeze the output, which gives silence. Volume, mixing and conversion to analog are handled elsewhere.

Top module: `noise_tone_channel`

## Requirements
- R1: While `rst_n` is low, `chanOut` is 0, the divider count is 0 and every noise register holds all ones. The first clock edge after release is therefore a sample edge.
- R2: The divider strobes on each edge where its count is 0 and then reloads with the stored N. Otherwise it decrements, so strobes are N+1 clocks apart. A write to N takes effect at the next reload, not at the current count.
- R3: `chanOut` changes only on the clock edge of a sample strobe, and never between strobes.
- R4: The three noise registers have widths 4, 5 and 17. Each shifts left once per clock and takes in bit0 the XOR of its top bit with bit 2, bit 2 and bit 13 respectively. The noise bit of each register is its top bit. They advance regardless of strobes, N writes or mode, and never reach all zeros.
- R5: With select 0, or the unused codes 6 and 7, the output toggles on every strobe (pure tone).
- R6: Selects 1, 2 and 3 toggle the output on a strobe only when the 4-bit, 5-bit or 17-bit noise bit is 1.
- R7: Selects 4 and 5 load the 4-bit or 17-bit noise bit straight into the output on a strobe, with no toggle stage.
- R8: Moving N to another value and back shifts the phase between divider and noise. The same N can then yield a different output sequence.
- R9: With select 4 and N = 14 the strobe period equals the 4-bit noise period. The output then stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the noise registers advance on every edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| freqWr | input | 1 | Write strobe for the frequency value |
| freqData | input | FREQ_W | New frequency value N |
| distSel | input | 3 | Distortion select (0..5; 6 and 7 act as 0) |
| chanOut | output | 1 | 1-bit channel output |

## Verification
The bench checks the write-timing case: an N written mid-count must not cut the running period short. A design that reloaded immediately would shift every later strobe and fail the cycle-exact comparison. The bench also runs N round trips with several detour lengths. A design that reset or resynchronised the noise registers on a write would give the same sequence each time. The bench holds N = 14 in a direct noise mode to check the frozen output. A design that stepped the noise only on strobes, or used a wrong tap, would keep changing the output. The tone and unused codes are compared against a toggle, to catch designs that add or skip the divide-by-two stage.

// File: rtl/noise_tone_pkg.sv
package noise_tone_pkg;

  typedef enum logic [2:0] {
    MODE_TONE    = 3'd0,
    MODE_P4_TOG  = 3'd1,
    MODE_P5_TOG  = 3'd2,
    MODE_P17_TOG = 3'd3,
    MODE_P4_DIR  = 3'd4,
    MODE_P17_DIR = 3'd5
  } distMode_e;

  // strobes handed from the divider control to the datapath
  typedef struct packed {
    logic sample;
    logic reload;
  } chanStrobe_t;

  localparam int NOISE_SRC = 3;
  localparam int SRC_P4  = 0;
  localparam int SRC_P5  = 1;
  localparam int SRC_P17 = 2;

endpackage

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int WIDTH = 4,
  parameter int TAP   = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic noiseBit
);
  localparam int TOP = WIDTH - 1;

  logic [TOP:0] state;
  logic feedback;

  assign feedback = state[TOP] ^ state[TAP];
  assign noiseBit = state[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '1;
    else        state <= {state[TOP-1:0], feedback};
  end
endmodule

// File: rtl/noise_tone_ctrl.sv
module noise_tone_ctrl
  import noise_tone_pkg::*;
#(
  parameter int FREQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freqWr,
  input  logic [FREQ_W-1:0] freqData,
  output chanStrobe_t       strobes,
  output logic [FREQ_W-1:0] divCount
);
  logic [FREQ_W-1:0] freqReg;
  logic              atZero;

  assign atZero         = (divCount == '0);
  assign strobes.sample = atZero;
  assign strobes.reload = atZero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      freqReg <= '0;
    else if (freqWr) freqReg <= freqData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      divCount <= '0;
    else if (atZero) divCount <= freqReg;
    else             divCount <= divCount - 1'b1;
  end
endmodule

// File: rtl/noise_tone_dp.sv
module noise_tone_dp
  import noise_tone_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  chanStrobe_t          strobes,
  input  logic [2:0]           distSel,
  output logic [NOISE_SRC-1:0] noiseBits,
  output logic                 chanOut
);
  localparam int SRC_W   [NOISE_SRC] = '{4, 5, 17};
  localparam int SRC_TAP [NOISE_SRC] = '{2, 2, 13};

  for (genvar g = 0; g < NOISE_SRC; g++) begin : g_src
    noise_lfsr #(.WIDTH(SRC_W[g]), .TAP(SRC_TAP[g])) u_lfsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .noiseBit (noiseBits[g])
    );
  end

  logic nextOut;

  always_comb begin
    nextOut = chanOut;
    case (distSel)
      MODE_P4_TOG:  nextOut = chanOut ^ noiseBits[SRC_P4];
      MODE_P5_TOG:  nextOut = chanOut ^ noiseBits[SRC_P5];
      MODE_P17_TOG: nextOut = chanOut ^ noiseBits[SRC_P17];
      MODE_P4_DIR:  nextOut = noiseBits[SRC_P4];
      MODE_P17_DIR: nextOut = noiseBits[SRC_P17];
      default:      nextOut = ~chanOut;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              chanOut <= 1'b0;
    else if (strobes.sample) chanOut <= nextOut;
  end
endmodule

// File: rtl/noise_tone_channel.sv
module noise_tone_channel
  import noise_tone_pkg::*;
#(
  parameter int FREQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freqWr,
  input  logic [FREQ_W-1:0] freqData,
  input  logic [2:0]        distSel,
  output logic              chanOut
);
  chanStrobe_t          strobes;
  logic [FREQ_W-1:0]    divCount;
  logic [NOISE_SRC-1:0] noiseBits;

  noise_tone_ctrl #(.FREQ_W(FREQ_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .freqWr   (freqWr),
    .freqData (freqData),
    .strobes  (strobes),
    .divCount (divCount)
  );

  noise_tone_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .distSel   (distSel),
    .noiseBits (noiseBits),
    .chanOut   (chanOut)
  );
endmodule

// File: rtl/noise_tone_chk.sv
module noise_tone_chk #(
  parameter int FREQ_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample,
  input logic [FREQ_W-1:0] divCount,
  input logic [2:0]        distSel,
  input logic [2:0]        noiseBits,
  input logic              chanOut
);
  // R3
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(chanOut));

  // R2
  countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (divCount != '0) |=> (divCount == $past(divCount) - 1'b1));

  // R5
  tone_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && (distSel == 3'd0 || distSel > 3'd5)) |=> (chanOut != $past(chanOut)));

  // R7
  direct_p4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && distSel == 3'd4) |=> (chanOut == $past(noiseBits[0])));

  // R7
  direct_p17_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && distSel == 3'd5) |=> (chanOut == $past(noiseBits[2])));

  // R6
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && distSel == 3'd1 && !noiseBits[0]) |=> $stable(chanOut));
endmodule

bind noise_tone_channel noise_tone_chk #(.FREQ_W(FREQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample    (strobes.sample),
  .divCount  (divCount),
  .distSel   (distSel),
  .noiseBits (noiseBits),
  .chanOut   (chanOut)
);

// File: tb/noise_tone_channel_tb.sv
module noise_tone_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FREQ_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              freqWr = 1'b0;
  logic [FREQ_W-1:0] freqData = '0;
  logic [2:0]        distSel = 3'd0;
  logic              chanOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  noise_tone_channel #(.FREQ_W(FREQ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .freqWr(freqWr), .freqData(freqData),
    .distSel(distSel), .chanOut(chanOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model, built from R1 R2 R4..R7
  logic [3:0]        m4;
  logic [4:0]        m5;
  logic [16:0]       m17;
  logic [FREQ_W-1:0] mCnt, mFreq;
  logic              mOut;
  logic              expQ[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m4 = '1; m5 = '1; m17 = '1; mCnt = '0; mFreq = '0; mOut = 1'b0;
      expQ.delete();
    end else begin
      if (mCnt == '0) begin
        case (distSel)
          3'd1: mOut = mOut ^ m4[3];
          3'd2: mOut = mOut ^ m5[4];
          3'd3: mOut = mOut ^ m17[16];
          3'd4: mOut = m4[3];
          3'd5: mOut = m17[16];
          default: mOut = ~mOut;
        endcase
        mCnt = mFreq;
      end else begin
        mCnt = mCnt - 1'b1;
      end
      if (freqWr) mFreq = freqData;
      m4  = {m4[2:0],  m4[3] ^ m4[2]};
      m5  = {m5[3:0],  m5[4] ^ m5[2]};
      m17 = {m17[15:0], m17[16] ^ m17[13]};
      expQ.push_back(mOut);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && expQ.size() > 0) begin
      logic e;
      e = expQ.pop_front();
      checks++;
      if (chanOut !== e) begin
        errors++;
        $display("FAIL R4 R5 R6 R7 scoreboard: actual %0b expected %0b at %0t", chanOut, e, $time);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeN(input logic [FREQ_W-1:0] n);
    @(negedge clk);
    freqWr = 1'b1; freqData = n;
    @(negedge clk);
    freqWr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seqA, seqB;
    int gap, changes, diffCnt;
    logic prev;

    // R1 reset state
    cycles(3);
    check("R1 output low in reset", chanOut, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first edge is a sample (tone toggles)", chanOut, 1);

    // R2 period N+1 in tone mode, N = 5
    writeN(8'd5);
    cycles(20);
    prev = chanOut;
    while (chanOut == prev) @(negedge clk);
    gap = 0; prev = chanOut;
    while (chanOut == prev) begin @(negedge clk); gap++; end
    check("R2 tone half period N+1", gap, 6);

    // R2 write lands at reload, not mid-count
    writeN(8'd40);
    prev = chanOut; gap = 0;
    while (chanOut == prev && gap < 100) begin @(negedge clk); gap++; end
    check("R2 old period finishes after write", gap <= 6, 1);
    cycles(200);

    // R5 unused code acts as tone
    distSel = 3'd7;
    writeN(8'd2);
    cycles(10);
    prev = chanOut; cycles(3);
    check("R5 code 7 toggles", chanOut != prev, 1);

    // R6 gated modes, R7 direct modes: covered by scoreboard over long runs
    for (int m = 1; m <= 5; m++) begin
      distSel = m[2:0];
      writeN(8'(m * 3 + 1));
      cycles(300);
    end

    // R9 lock: select 4 with N = 14 freezes output
    distSel = 3'd4;
    writeN(8'd14);
    cycles(40);
    changes = 0; prev = chanOut;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (chanOut != prev) changes++;
      prev = chanOut;
    end
    check("R9 output constant at N=14 select 4", changes, 0);

    // R8 round trip shifts phase; R4 noise free-runs through writes
    writeN(8'd3);
    cycles(40);
    for (int i = 0; i < 32; i++) begin @(negedge clk); seqA[i] = chanOut; end
    diffCnt = 0;
    for (int d = 1; d <= 6; d++) begin
      writeN(8'd0);
      cycles(d);
      writeN(8'd3);
      cycles(40);
      for (int i = 0; i < 32; i++) begin @(negedge clk); seqB[i] = chanOut; end
      if (seqB != seqA) diffCnt++;
    end
    check("R8 round trip changes pattern", diffCnt > 0, 1);

    // R4 noise never stuck: select 5 keeps changing
    distSel = 3'd5;
    writeN(8'd1);
    cycles(10);
    changes = 0; prev = chanOut;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (chanOut != prev) changes++;
      prev = chanOut;
    end
    check("R4 17-bit noise keeps moving", changes > 10, 1);

    // R3 output steady between strobes with large N
    distSel = 3'd0;
    writeN(8'd60);
    cycles(130);
    prev = chanOut; changes = 0;
    while (chanOut == prev) @(negedge clk);
    prev = chanOut;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (chanOut != prev) changes++;
    end
    check("R3 no change between strobes", changes, 0);

    cycles(5);
    finish_run();
  end
endmodule